// File: doc/BRIEF.md
# Burst Address Counter

This block sits in front of one port of a memory core. It produces the address that the core sees. The address can come from outside, or from an internal counter so that a port can run a burst of sequential accesses without supplying a new address each cycle. An address strobe copies the external address into the counter. A count enable then advances the counter by one word per clock. A clear input returns the counter to zero. When the counter passes the top of the array it wraps to address zero.

All three controls are active low and are sampled on the rising clock edge. The output comes straight from the counter register, so an action taken at an edge is visible on `mem_addr` right after that edge. When more than one control is active at once, clear wins, then load, then increment. With no control active the counter keeps its value, so the last address is used again. The width of the address is a parameter, the base-2 logarithm of the memory depth.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `mem_addr` is 0. The reset is asynchronous.
- R2: If `clear_n` is low at a rising edge, `mem_addr` is 0 after that edge, whatever `load_n`, `count_n` and `ext_addr` are.
- R3: If `clear_n` is high and `load_n` is low at a rising edge, `mem_addr` takes the value of `ext_addr` after that edge, even when `count_n` is also low.
- R4: If `clear_n` and `load_n` are high and `count_n` is low at a rising edge, `mem_addr` increases by exactly one.
- R5: An increment from the last address (all ones, 16'hFFFF at the default width) gives address 0.
- R6: If all three controls are high at a rising edge, `mem_addr` keeps its value, and `ext_addr` has no effect on it.
- R7: During an increment, the value on `ext_addr` has no effect on `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_addr | input | ADDR_W | Externally supplied address |
| load_n | input | 1 | Address strobe, active low: load `ext_addr` into the counter |
| count_n | input | 1 | Count enable, active low: advance the counter by one |
| clear_n | input | 1 | Counter clear, active low: set the counter to 0 |
| mem_addr | output | ADDR_W | Address presented to the memory core |

## Verification
The embedded properties are checked on every clock after reset. They cover the four control outcomes (clear, load, increment, hold) and the rollover from all ones to zero, so the priority between the controls is enforced on every edge. Only the bench scenarios can show some behaviours. These are the value held while reset is asserted, the asynchronous reset in the middle of a burst, and the fact that a changing `ext_addr` leaves no trace at all over several cycles of counting and holding.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              load_n,
  input  logic              count_n,
  input  logic              clear_n,
  output logic [ADDR_W-1:0] mem_addr
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] cnt_d;
  logic              do_clear, do_load, do_inc;

  assign do_clear = ~clear_n;
  assign do_load  = clear_n & ~load_n;
  assign do_inc   = clear_n & load_n & ~count_n;

  always_comb begin
    cnt_d = cnt_q;
    if (do_clear)    cnt_d = '0;
    else if (do_load) cnt_d = ext_addr;
    else if (do_inc)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign mem_addr = cnt_q;

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> mem_addr == '0);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n) |=> mem_addr == $past(ext_addr));

  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && !count_n) |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && !count_n && mem_addr == TOP_ADDR) |=> mem_addr == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && count_n) |=> $stable(mem_addr));

endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;

  localparam int W = 16;
  localparam int NV = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] ext_addr = '0;
  logic         load_n = 1'b1, count_n = 1'b1, clear_n = 1'b1;
  logic [W-1:0] mem_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .load_n(load_n), .count_n(count_n), .clear_n(clear_n),
    .mem_addr(mem_addr)
  );

  // {clear_n, load_n, count_n, ext_addr, expected mem_addr}
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 16'h1234, 16'h1234},  // R3 load
    {1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h1235},  // R4 R7
    {1'b1, 1'b1, 1'b0, 16'h0000, 16'h1236},  // R4 R7
    {1'b1, 1'b1, 1'b1, 16'hAAAA, 16'h1236},  // R6 hold
    {1'b1, 1'b0, 1'b0, 16'h00FE, 16'h00FE},  // R3 load over count
    {1'b1, 1'b1, 1'b0, 16'h5A5A, 16'h00FF},  // R4
    {1'b1, 1'b1, 1'b0, 16'h0001, 16'h0100},  // R4 carry
    {1'b0, 1'b0, 1'b0, 16'h5555, 16'h0000},  // R2 clear over all
    {1'b1, 1'b0, 1'b1, 16'hFFFE, 16'hFFFE},  // R3
    {1'b1, 1'b1, 1'b0, 16'h0000, 16'hFFFF},  // R4
    {1'b1, 1'b1, 1'b0, 16'h1111, 16'h0000},  // R5 wrap
    {1'b1, 1'b1, 1'b1, 16'hFFFF, 16'h0000},  // R6
    {1'b0, 1'b1, 1'b1, 16'h7777, 16'h0000}   // R2
  };
  localparam int TAG [NV] = '{3, 7, 7, 6, 3, 4, 4, 2, 3, 4, 5, 6, 2};

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (mem_addr !== exp) begin
      errors++;
      $display("FAIL %s mem_addr=%h expected=%h", req, mem_addr, exp);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic n, input logic [W-1:0] a);
    clear_n = c; load_n = l; count_n = n; ext_addr = a;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:16]);
      @(negedge clk);
      check($sformatf("R%0d", TAG[i]), VEC[i][15:0]);
    end

    // R5 wrap right after a load of the top address
    drive(1'b1, 1'b0, 1'b1, 16'hFFFF);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b0, 16'h4321);
    @(negedge clk);
    check("R5", 16'h0000);

    // R7 long burst with a changing external address
    drive(1'b1, 1'b0, 1'b1, 16'h0040);
    @(negedge clk);
    for (int k = 1; k <= 8; k++) begin
      drive(1'b1, 1'b1, 1'b0, W'(k * 16'h1357));
      @(negedge clk);
      check("R7", W'(16'h0040 + k));
    end

    // R6 several hold cycles with address noise
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 1'b1, 1'b1, W'(16'hBEEF ^ k));
      @(negedge clk);
      check("R6", 16'h0048);
    end

    // R1 asynchronous reset mid-burst
    drive(1'b1, 1'b1, 1'b0, '0);
    #2 rst_n = 1'b0;
    #1 check("R1", '0);
    @(negedge clk);
    check("R1", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4", 16'h0001);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule